// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the chain of extended capability headers kept in the 4 KB configuration space of a PCIe function. The chain always starts at byte offset 0x100. Each entry starts with a 32-bit header that holds a capability ID, a version and the offset of the next entry. The block reaches that memory through a word read port, which has one cycle of latency, and a word write port. It serves two commands. A find command looks for a capability ID and returns the offset of the matching entry and the offset of the entry before it. An append command adds a new header at an offset the caller gives and links it into the chain. Searching for the reserved ID 0 never matches, so an append uses that search to locate the tail. An all-zero header at 0x100 means the chain is empty.

Control is a single state machine:

- **ST_IDLE** waits for `start`. It latches the command and goes to ST_READ, or to ST_FIN when an append has bad arguments.
- **ST_READ** issues one header read at the current offset.
- **ST_EVAL** judges the returned header. The outcomes are:
  - base append, which goes to ST_NEW;
  - empty, hit, or tail of a find, which go to ST_FIN;
  - tail of an append, which goes to ST_LINK;
  - bad pointer or step limit, which go to ST_FIN with an error;
  - follow, which goes back to ST_READ.
- **ST_LINK** rewrites the tail's next field and goes to ST_NEW.
- **ST_NEW** writes the new header and goes to ST_FIN.
- **ST_FIN** pulses `done` and returns to ST_IDLE.

Results and the error flag hold until the next accepted command.

Top module: `extcap_list_walker`

## Requirements
- R1: Header layout is the capability ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. A next offset of 0 marks the last entry.
- R2: A find first reads offset 0x100. If that header is all zero, the result is found = 0 and previous = 0 with no error, and `done` rises on the 3rd clock edge, counting the edge that samples `start` as the 1st.
- R3: A find whose ID (not 0) matches the header at the k-th visited entry returns found = that entry's offset and previous = the offset of the entry before it (0 for the entry at 0x100). `done` rises on edge 2k+1.
- R4: When a find reaches the last entry without a match, the result is found = 0 and previous = the last entry's offset. A search for ID 0 never matches and always ends this way.
- R5: A next offset that is below 0x100, above 0xFF8 or not a multiple of 4 is never read. The command ends with the error flag set and found = previous = 0. The limits 0x100 and 0xFF8 themselves are legal.
- R6: After MAX_STEPS header reads (default 1024) without reaching an end, the walk stops with the error flag set. `done` rises on edge 2·MAX_STEPS+1.
- R7: An append at offset 0x100 reads that header and writes it back with the new ID and version and the old next field. It returns found = 0x100 and previous = 0, and `done` rises on edge 4.
- R8: An append at any other offset walks to the tail and makes two writes, in this order: first the tail header with its next field set to the new offset and its ID and version unchanged, then the new header with next = 0. It returns found = new offset and previous = tail offset, and `done` rises on edge 2k+3, where k is the number of entries in the chain.
- R9: An append is rejected when any of these holds: the offset is not a multiple of 4, the offset is below 0x100, the size is below 8, or offset + size ≥ 4096. A rejected append makes no memory access, sets the error flag and raises `done` on edge 1.
- R10: An append at an offset other than 0x100 on an empty chain sets the error flag and writes nothing.
- R11: After reset, `done`, the error flag and both offsets are 0. `done` is a one-cycle pulse. Results hold until the next accepted `start`. A `start` while a command runs is ignored.
- R12: Each visited header costs exactly one read, whose data is used one cycle later. A read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted only when idle |
| op | input | 1 | 0 = find, 1 = append |
| cap_id | input | 16 | Capability ID to search for or to append |
| cap_ver | input | 4 | Version for the appended header |
| new_off | input | 12 | Byte offset of the entry to append |
| new_size | input | 13 | Byte size of the entry to append |
| mem_rd_en | output | 1 | Header read request |
| mem_rd_addr | output | 12 | Byte address of the read |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Header write strobe |
| mem_wr_addr | output | 12 | Byte address of the write |
| mem_wr_data | output | 32 | Header written |
| done | output | 1 | One-cycle completion pulse |
| found_off | output | 12 | Offset found or appended, 0 if none |
| prev_off | output | 12 | Offset of the preceding entry, 0 if none |
| err | output | 1 | Command ended in error |

## Verification
The loop guard is the hardest case to reach, because a well-formed chain always ends. The stimulus builds a header at 0x100 whose next field points back to itself. The walk then runs 1024 steps, and the bench checks that the error appears at the exact edge it predicts. Next pointers are also placed exactly on the legal limits and one step past them, and a second `start` is pulsed in the middle of a walk. Every `done` timing, each read count and the ordered list of writes are compared with a behavioural model that walks the bench's own copy of the memory.

// File: rtl/extcap_pkg.sv
package extcap_pkg;

    localparam int unsigned CFG_AW    = 12;
    localparam int unsigned CFG_BYTES = 4096;
    localparam logic [CFG_AW-1:0] EXT_BASE = 12'h100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_LINK,
        ST_NEW,
        ST_FIN
    } walk_state_e;

    typedef enum logic {
        OP_FIND   = 1'b0,
        OP_APPEND = 1'b1
    } walk_op_e;

    typedef enum logic [2:0] {
        EV_BASE_APPEND,
        EV_EMPTY,
        EV_HIT,
        EV_TAIL,
        EV_BAD,
        EV_FOLLOW
    } eval_e;

    typedef struct packed {
        logic [11:0] nxt;
        logic [3:0]  ver;
        logic [15:0] id;
    } ext_hdr_t;

endpackage

// File: rtl/extcap_off_check.sv
module extcap_off_check #(
    parameter int unsigned AW = 12,
    parameter int unsigned LO = 256,
    parameter int unsigned HI = 4088
) (
    input  logic [AW-1:0] off,
    output logic          ok
);
    logic aligned;
    logic in_range;

    always_comb begin
        aligned  = (off[1:0] == 2'b00);
        in_range = (32'(off) >= LO) && (32'(off) <= HI);
        ok       = aligned && in_range;
    end
endmodule

// File: rtl/extcap_append_check.sv
module extcap_append_check #(
    parameter int unsigned AW     = 12,
    parameter int unsigned SW     = 13,
    parameter int unsigned LO     = 256,
    parameter int unsigned SPACE  = 4096,
    parameter int unsigned MIN_SZ = 8
) (
    input  logic [AW-1:0] off,
    input  logic [SW-1:0] size,
    output logic          ok
);
    logic [31:0] end_byte;

    always_comb begin
        end_byte = 32'(off) + 32'(size);
        ok = (off[1:0] == 2'b00)
          && (32'(off) >= LO)
          && (32'(size) >= MIN_SZ)
          && (end_byte < SPACE);
    end
endmodule

// File: rtl/extcap_step_guard.sv
module extcap_step_guard #(
    parameter int unsigned MAX_STEPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned CW = $clog2(MAX_STEPS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_STEPS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == LIMIT);

    AST_NO_READ_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit); // R6
endmodule

// File: rtl/extcap_list_walker.sv
module extcap_list_walker
    import extcap_pkg::*;
#(
    parameter int unsigned MAX_STEPS = 1024,
    parameter int unsigned SIZE_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [15:0]       cap_id,
    input  logic [3:0]        cap_ver,
    input  logic [11:0]       new_off,
    input  logic [SIZE_W-1:0] new_size,
    output logic              mem_rd_en,
    output logic [11:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [11:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              done,
    output logic [11:0]       found_off,
    output logic [11:0]       prev_off,
    output logic              err
);
    localparam int unsigned LO_OFF   = 32'(EXT_BASE);
    localparam int unsigned LAST_OFF = CFG_BYTES - 8;
    localparam int unsigned MIN_SIZE = 8;

    walk_state_e state_q, state_d;
    walk_op_e    op_q;
    logic [15:0] id_q;
    logic [3:0]  ver_q;
    logic [11:0] off_q;
    logic [11:0] cur_q;
    logic [11:0] prev_q;
    logic        first_q;
    ext_hdr_t    tail_hdr_q;
    logic [11:0] new_next_q;
    logic [11:0] found_q;
    logic [11:0] prevo_q;
    logic        err_q;

    ext_hdr_t    hdr;
    eval_e       outcome;
    logic        nxt_ok;
    logic        app_ok;
    logic        at_limit;
    logic        accept;

    assign hdr    = mem_rd_data;
    assign accept = (state_q == ST_IDLE) && start;

    extcap_off_check #(
        .AW (CFG_AW),
        .LO (LO_OFF),
        .HI (LAST_OFF)
    ) u_next_chk (
        .off (hdr.nxt),
        .ok  (nxt_ok)
    );

    extcap_append_check #(
        .AW     (CFG_AW),
        .SW     (SIZE_W),
        .LO     (LO_OFF),
        .SPACE  (CFG_BYTES),
        .MIN_SZ (MIN_SIZE)
    ) u_app_chk (
        .off  (new_off),
        .size (new_size),
        .ok   (app_ok)
    );

    extcap_step_guard #(
        .MAX_STEPS (MAX_STEPS)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .inc      (state_q == ST_READ),
        .at_limit (at_limit)
    );

    // Judgement of the header returned in ST_EVAL
    always_comb begin
        if (op_q == OP_APPEND && off_q == EXT_BASE) begin
            outcome = EV_BASE_APPEND;
        end else if (first_q && mem_rd_data == 32'h0) begin
            outcome = EV_EMPTY;
        end else if (op_q == OP_FIND && id_q != 16'h0 && hdr.id == id_q) begin
            outcome = EV_HIT;
        end else if (hdr.nxt == 12'h0) begin
            outcome = EV_TAIL;
        end else if (!nxt_ok || at_limit) begin
            outcome = EV_BAD;
        end else begin
            outcome = EV_FOLLOW;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (op == OP_APPEND && !app_ok) ? ST_FIN : ST_READ;
                end
            end
            ST_READ: state_d = ST_EVAL;
            ST_EVAL: begin
                unique case (outcome)
                    EV_BASE_APPEND: state_d = ST_NEW;
                    EV_TAIL:        state_d = (op_q == OP_APPEND) ? ST_LINK : ST_FIN;
                    EV_FOLLOW:      state_d = ST_READ;
                    default:        state_d = ST_FIN;
                endcase
            end
            ST_LINK: state_d = ST_NEW;
            ST_NEW:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Command context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_FIND;
            id_q       <= '0;
            ver_q      <= '0;
            off_q      <= '0;
            cur_q      <= '0;
            prev_q     <= '0;
            first_q    <= 1'b0;
            tail_hdr_q <= '0;
            new_next_q <= '0;
            found_q    <= '0;
            prevo_q    <= '0;
            err_q      <= 1'b0;
        end else if (accept) begin
            op_q    <= walk_op_e'(op);
            id_q    <= cap_id;
            ver_q   <= cap_ver;
            off_q   <= new_off;
            cur_q   <= EXT_BASE;
            prev_q  <= '0;
            first_q <= 1'b1;
            found_q <= '0;
            prevo_q <= '0;
            err_q   <= (op == OP_APPEND) && !app_ok;
        end else if (state_q == ST_EVAL) begin
            unique case (outcome)
                EV_BASE_APPEND: begin
                    new_next_q <= hdr.nxt;
                    found_q    <= EXT_BASE;
                    prevo_q    <= '0;
                end
                EV_EMPTY: begin
                    err_q <= (op_q == OP_APPEND);
                end
                EV_HIT: begin
                    found_q <= cur_q;
                    prevo_q <= prev_q;
                end
                EV_TAIL: begin
                    prevo_q <= cur_q;
                    if (op_q == OP_APPEND) begin
                        tail_hdr_q <= hdr;
                        new_next_q <= '0;
                        found_q    <= off_q;
                    end else begin
                        found_q <= '0;
                    end
                end
                EV_BAD: begin
                    err_q <= 1'b1;
                end
                default: begin
                    prev_q  <= cur_q;
                    cur_q   <= hdr.nxt;
                    first_q <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        done        = (state_q == ST_FIN);
        found_off   = found_q;
        prev_off    = prevo_q;
        err         = err_q;
        mem_rd_en   = (state_q == ST_READ);
        mem_rd_addr = cur_q;
        mem_wr_en   = (state_q == ST_LINK) || (state_q == ST_NEW);
        if (state_q == ST_LINK) begin
            mem_wr_addr = prevo_q;
            mem_wr_data = {off_q, tail_hdr_q.ver, tail_hdr_q.id};
        end else begin
            mem_wr_addr = off_q;
            mem_wr_data = {new_next_q, ver_q, id_q};
        end
    end

    AST_RD_IN_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00 && mem_rd_addr >= EXT_BASE
                       && 32'(mem_rd_addr) <= LAST_OFF)); // R5
    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R12
    AST_READ_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (found_off == 12'h0 && prev_off == 12'h0)); // R5
    AST_LINK_THEN_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && state_q == ST_LINK) |=> (mem_wr_en && mem_wr_addr == off_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> ($stable(found_off) && $stable(prev_off)
                                            && $stable(err))); // R11
endmodule

// File: tb/extcap_list_walker_tb_top.sv
module extcap_list_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_STEPS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic [15:0] cap_id = '0;
    logic [3:0]  cap_ver = '0;
    logic [11:0] new_off = '0;
    logic [12:0] new_size = '0;
    logic        mem_rd_en, mem_wr_en, done, err;
    logic [11:0] mem_rd_addr, mem_wr_addr, found_off, prev_off;
    logic [31:0] mem_rd_data, mem_wr_data;

    logic [31:0] cfg [0:1023];
    logic [31:0] rd_q = '0;
    logic        tb_we = 1'b0, tb_clr = 1'b0, rec_on = 1'b0, rec_clr = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [31:0] tb_data = '0;

    int          rd_seen, clash;
    int          gw_a[$];
    logic [31:0] gw_d[$];

    int          checks = 0, fails = 0;
    int          exp_found, exp_prev, exp_cyc, exp_reads;
    bit          exp_err;
    int          ew_a[$];
    logic [31:0] ew_d[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    extcap_list_walker #(.MAX_STEPS(MAX_STEPS), .SIZE_W(13)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cap_id(cap_id),
        .cap_ver(cap_ver), .new_off(new_off), .new_size(new_size),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .found_off(found_off), .prev_off(prev_off), .err(err));

    assign mem_rd_data = rd_q;

    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 1024; i++) cfg[i] <= '0;
        end else if (tb_we) begin
            cfg[tb_addr[11:2]] <= tb_data;
        end
        if (mem_wr_en) cfg[mem_wr_addr[11:2]] <= mem_wr_data;
        if (mem_rd_en) rd_q <= cfg[mem_rd_addr[11:2]];
    end

    always @(posedge clk) begin
        if (rec_clr) begin
            rd_seen = 0; clash = 0; gw_a.delete(); gw_d.delete();
        end else if (rec_on) begin
            if (mem_rd_en) rd_seen++;
            if (mem_rd_en && mem_wr_en) clash++;
            if (mem_wr_en) begin gw_a.push_back(int'(mem_wr_addr)); gw_d.push_back(mem_wr_data); end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int nxt, input int ver, input int id);
        return {nxt[11:0], ver[3:0], id[15:0]};
    endfunction

    task automatic wipe();
        @(negedge clk); tb_clr = 1'b1;
        @(negedge clk); tb_clr = 1'b0;
    endtask

    task automatic put(input int off, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_addr = off[11:0]; tb_data = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    // Behavioural reference: walks the bench copy of the memory
    task automatic model(input bit op_i, input int id, input int ver, input int off, input int size);
        int cur, prv, nxt;
        bit first;
        logic [31:0] h;
        exp_reads = 0; exp_err = 0; exp_found = 0; exp_prev = 0;
        ew_a.delete(); ew_d.delete();
        if (op_i && !(off % 4 == 0 && off >= 256 && size >= 8 && off + size < 4096)) begin
            exp_err = 1; exp_cyc = 1; return;
        end
        cur = 256; prv = 0; first = 1;
        forever begin
            exp_reads++;
            h = cfg[cur / 4];
            if (op_i && off == 256) begin
                ew_a.push_back(256); ew_d.push_back({h[31:20], ver[3:0], id[15:0]});
                exp_found = 256; exp_cyc = 2 * exp_reads + 2; return;
            end
            if (first && h == 0) begin
                exp_err = op_i; exp_cyc = 2 * exp_reads + 1; return;
            end
            if (!op_i && id != 0 && int'(h[15:0]) == id) begin
                exp_found = cur; exp_prev = prv; exp_cyc = 2 * exp_reads + 1; return;
            end
            nxt = int'(h[31:20]);
            if (nxt == 0) begin
                exp_prev = cur;
                if (op_i) begin
                    ew_a.push_back(cur); ew_d.push_back({off[11:0], h[19:0]});
                    ew_a.push_back(off); ew_d.push_back(mk(0, ver, id));
                    exp_found = off; exp_cyc = 2 * exp_reads + 3;
                end else begin
                    exp_cyc = 2 * exp_reads + 1;
                end
                return;
            end
            if (nxt % 4 != 0 || nxt < 256 || nxt > 4088 || exp_reads == MAX_STEPS) begin
                exp_err = 1; exp_cyc = 2 * exp_reads + 1; return;
            end
            prv = cur; cur = nxt; first = 0;
        end
    endtask

    task automatic run_op(input bit op_i, input int id, input int ver, input int off,
                          input int size, input string tag, input bit poke);
        int cnt;
        model(op_i, id, ver, off, size);
        @(negedge clk); rec_clr = 1'b1;
        @(negedge clk); rec_clr = 1'b0; rec_on = 1'b1;
        op = op_i; cap_id = id[15:0]; cap_ver = ver[3:0]; new_off = off[11:0]; new_size = size[12:0];
        start = 1'b1;
        @(negedge clk);
        cap_id = 16'hBEEF; op = 1'b0; new_off = 12'h004; cnt = 1;
        forever begin
            start = poke && (cnt == 2);   // R11 start while busy is ignored
            chk(done == (cnt == exp_cyc), tag, "done timing", longint'(done), longint'(cnt == exp_cyc));
            if (done) begin
                chk(int'(found_off) == exp_found, tag, "found offset", found_off, exp_found);
                chk(int'(prev_off) == exp_prev, tag, "previous offset", prev_off, exp_prev);
                chk(err == exp_err, tag, "error flag", err, exp_err);
                break;
            end
            if (cnt > exp_cyc + 4) begin
                chk(1'b0, tag, "done never rose", cnt, exp_cyc);
                break;
            end
            @(negedge clk); cnt++;
        end
        start = 1'b0; rec_on = 1'b0;
        chk(rd_seen == exp_reads, "R12", {tag, " read count"}, rd_seen, exp_reads);
        chk(clash == 0, "R12", "read and write together", clash, 0);
        chk(gw_a.size() == ew_a.size(), tag, "write count", gw_a.size(), ew_a.size());
        for (int i = 0; i < gw_a.size() && i < ew_a.size(); i++) begin
            chk(gw_a[i] == ew_a[i], tag, "write address", gw_a[i], ew_a[i]);
            chk(gw_d[i] == ew_d[i], tag, "write data", gw_d[i], ew_d[i]);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!done && int'(found_off) == exp_found && int'(prev_off) == exp_prev && err == exp_err,
                "R11", "result hold", found_off, exp_found);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rd_seen = 0; clash = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !err && found_off == 0 && prev_off == 0 && !mem_rd_en && !mem_wr_en,
            "R11", "reset state", {done, err}, 0);
        wipe();
        run_op(0, 5, 0, 0, 0, "R2", 0);
        // chain 0x100(id1) -> 0x200(id2) -> 0x180(id3), R1 layout
        put(12'h100, mk(12'h200, 1, 1));
        put(12'h200, mk(12'h180, 2, 2));
        put(12'h180, mk(0, 3, 3));
        run_op(0, 3, 0, 0, 0, "R3", 0);
        run_op(0, 1, 0, 0, 0, "R3", 0);
        run_op(0, 2, 0, 0, 0, "R3", 1);
        run_op(0, 9, 0, 0, 0, "R4", 0);
        run_op(0, 0, 0, 0, 0, "R4", 0);
        // append at 0x100 keeps next, R7
        run_op(1, 16'h77, 2, 12'h100, 16, "R7", 0);
        run_op(0, 16'h77, 0, 0, 0, "R7", 0);
        // append elsewhere, R8
        run_op(1, 16'h1234, 1, 12'h300, 32, "R8", 0);
        run_op(0, 16'h1234, 0, 0, 0, "R8", 0);
        run_op(1, 16'h55, 3, 12'hFE8, 16, "R9", 0);
        // rejected appends, R9
        run_op(1, 16'h66, 1, 12'h0FC, 16, "R9", 0);
        run_op(1, 16'h66, 1, 12'h302, 16, "R9", 0);
        run_op(1, 16'h66, 1, 12'h400, 4, "R9", 0);
        run_op(1, 16'h66, 1, 12'hFF0, 16, "R9", 0);
        run_op(0, 0, 0, 0, 0, "R9", 0);
        // empty chain append, R10
        wipe();
        run_op(1, 16'h88, 1, 12'h200, 16, "R10", 0);
        run_op(0, 0, 0, 0, 0, "R10", 0);
        // pointer limits, R5
        put(12'h100, mk(12'h0FC, 1, 1));
        run_op(0, 9, 0, 0, 0, "R5", 0);
        put(12'h100, mk(12'hFFC, 1, 1));
        run_op(0, 9, 0, 0, 0, "R5", 0);
        put(12'h100, mk(12'h202, 1, 1));
        run_op(0, 9, 0, 0, 0, "R5", 0);
        put(12'h100, mk(12'hFF8, 1, 1));
        put(12'hFF8, mk(0, 1, 4));
        run_op(0, 4, 0, 0, 0, "R5", 0);
        // self loop, R6
        put(12'h100, mk(12'h100, 1, 1));
        run_op(0, 9, 0, 0, 0, "R6", 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule